// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame is kept or discarded by looking only at its 48-bit destination address. The frame parser presents the address together with a one-cycle strobe. One clock later the filter raises a decision strobe along with a keep/discard bit.

The behaviour is set by a 4-bit control word. One bit decides what happens to broadcast frames. A 2-bit field sets the multicast policy. One bit chooses whether the small address table works as an allow list or as a block list. The table holds six programmable addresses, and each entry has its own enable bit. The control word, the table and the enables are sampled in the same cycle as the address strobe.

Broadcast handling is checked first. The multicast policy is applied next. The table decides everything else.

Top module: `dst_addr_filter`

## Requirements
- R1: A broadcast address (all 48 bits set) is accepted when control bit 0 is 1, whatever the other control bits and table contents are.
- R2: A broadcast address is dropped when control bit 0 is 0, whatever the other control bits and table contents are.
- R3: A non-broadcast multicast address is dropped when control bits [2:1] equal 1. An address is multicast when bit 40 of the address is set; bit 40 is the lowest bit of the first transmitted byte, and the first byte sits in bits [47:40].
- R4: A non-broadcast multicast address is accepted when control bits [2:1] equal 2.
- R5: When control bits [2:1] equal 0 or 3, a non-broadcast multicast address gets the table decision of R6 and R7.
- R6: When control bit 3 is 1 (allow list), a unicast address that equals an enabled entry is accepted, and one that equals no enabled entry is dropped.
- R7: When control bit 3 is 0 (block list), a unicast address that equals an enabled entry is dropped, and one that equals no enabled entry is accepted.
- R8: An entry whose enable bit is 0 never counts as a match, even if its stored address equals the input.
- R9: `decision_valid` is high exactly in the cycle after an address strobe, and `accept` is updated in that same cycle. Without a strobe, `decision_valid` is low and `accept` keeps its value.
- R10: While `rst_n` is low at a clock edge, both `decision_valid` and `accept` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl | input | 4 | Bit 3 table mode, bits [2:1] multicast policy, bit 0 broadcast accept |
| table_addr | input | 288 | Six 48-bit entries; entry i sits in bits [48*i+47:48*i] |
| table_en | input | 6 | Per-entry enable |
| dst_addr | input | 48 | Destination address; first byte in bits [47:40] |
| dst_valid | input | 1 | Address strobe |
| decision_valid | output | 1 | Decision strobe, one cycle after `dst_valid` |
| accept | output | 1 | 1 = keep frame, 0 = discard |

## Verification
Any fault in the class detectors, the table comparators or the policy logic shows up as a wrong `accept` in the very next cycle after the strobe. The decision is one register deep, so the bench never has to wait for a state to build up before it can see an error.

A stuck enable gating shows up only when the bench drives an address equal to a disabled entry. A reversed table mode turns every unicast result upside down. A fault in the capture enable shows up as `accept` changing in a cycle with no strobe.

// File: rtl/daf_pkg.sv
// Shared types for the destination address filter.
// Assumes a 4-bit control word laid out as {table mode, multicast policy[1:0], broadcast accept}.
package daf_pkg;
    localparam int MAC_W = 48;

    typedef enum logic [1:0] {
        MC_USE_TABLE  = 2'd0,
        MC_DROP_ALL   = 2'd1,
        MC_PASS_ALL   = 2'd2,
        MC_USE_TABLE3 = 2'd3
    } mc_policy_t;

    typedef struct packed {
        logic       tbl_allow;
        mc_policy_t mc_policy;
        logic       bc_accept;
    } filt_ctrl_t;
endpackage

// File: rtl/daf_match_table.sv
// Compares one address against N programmable entries; an entry can hit only when enabled.
// Assumes entries are packed flat, entry i at [W*i +: W]. Purely combinational.
module daf_match_table #(
    parameter int N_ENTRIES = 6,
    parameter int ADDR_W    = 48
) (
    input  logic [N_ENTRIES*ADDR_W-1:0] entries,
    input  logic [N_ENTRIES-1:0]        enables,
    input  logic [ADDR_W-1:0]           addr,
    output logic                        hit
);
    logic [N_ENTRIES-1:0] hit_vec;

    genvar gi;
    generate
        for (gi = 0; gi < N_ENTRIES; gi++) begin : g_cmp
            // per-entry equality gated by its enable
            always_comb hit_vec[gi] = enables[gi] && (entries[gi*ADDR_W +: ADDR_W] == addr);
        end
    endgenerate

    // any enabled entry matched
    always_comb hit = |hit_vec;
endmodule

// File: rtl/daf_classify.sv
// Detects broadcast (all ones) and multicast (group bit = lowest bit of the first byte) addresses.
// Assumes the first transmitted byte occupies the top byte of the address.
module daf_classify #(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_bcast,
    output logic              is_mcast
);
    localparam int GROUP_BIT = ADDR_W - 8;

    // address class flags
    always_comb begin
        is_bcast = &addr;
        is_mcast = addr[GROUP_BIT];
    end
endmodule

// File: rtl/daf_decide.sv
// Applies broadcast, multicast and table policy and registers the verdict.
// Assumes classification and table hit are valid in the strobe cycle.
module daf_decide
    import daf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  filt_ctrl_t ctrl,
    input  logic       is_bcast,
    input  logic       is_mcast,
    input  logic       tbl_hit,
    input  logic       strobe,
    output logic       dec_valid,
    output logic       dec_accept
);
    logic verdict;
    logic tbl_verdict;

    // priority: broadcast, then multicast policy, then table
    always_comb begin
        tbl_verdict = tbl_hit ? ctrl.tbl_allow : !ctrl.tbl_allow;
        if (is_bcast)
            verdict = ctrl.bc_accept;
        else if (is_mcast && ctrl.mc_policy == MC_DROP_ALL)
            verdict = 1'b0;
        else if (is_mcast && ctrl.mc_policy == MC_PASS_ALL)
            verdict = 1'b1;
        else
            verdict = tbl_verdict;
    end

    // register strobe and capture verdict on strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid <= strobe;
            if (strobe)
                dec_accept <= verdict;
        end
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> dec_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !dec_valid);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(dec_accept));
    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (!dec_valid && !dec_accept));
endmodule

// File: rtl/dst_addr_filter.sv
// Top: destination address filter with broadcast, multicast and table policy.
// Assumes inputs are stable in the strobe cycle; decision appears one cycle later.
module dst_addr_filter #(
    parameter int N_ENTRIES = 6,
    parameter int ADDR_W    = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  ctrl,
    input  logic [N_ENTRIES*ADDR_W-1:0] table_addr,
    input  logic [N_ENTRIES-1:0]        table_en,
    input  logic [ADDR_W-1:0]           dst_addr,
    input  logic                        dst_valid,
    output logic                        decision_valid,
    output logic                        accept
);
    import daf_pkg::*;

    localparam int GROUP_BIT = ADDR_W - 8;

    filt_ctrl_t ctrl_s;
    logic       bcast, mcast, hit;

    // reinterpret control bits as policy fields
    always_comb ctrl_s = filt_ctrl_t'(ctrl);

    daf_classify #(.ADDR_W(ADDR_W)) u_cls (
        .addr     (dst_addr),
        .is_bcast (bcast),
        .is_mcast (mcast)
    );

    daf_match_table #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_tbl (
        .entries (table_addr),
        .enables (table_en),
        .addr    (dst_addr),
        .hit     (hit)
    );

    daf_decide u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl_s),
        .is_bcast   (bcast),
        .is_mcast   (mcast),
        .tbl_hit    (hit),
        .strobe     (dst_valid),
        .dec_valid  (decision_valid),
        .dec_accept (accept)
    );

    a_r1_bcast_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && (&dst_addr) && ctrl[0]) |=> accept);
    a_r2_bcast_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && (&dst_addr) && !ctrl[0]) |=> !accept);
    a_r3_mc_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_addr[GROUP_BIT] && !(&dst_addr) && ctrl[2:1] == 2'd1) |=> !accept);
    a_r4_mc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_addr[GROUP_BIT] && !(&dst_addr) && ctrl[2:1] == 2'd2) |=> accept);
endmodule

// File: tb/dst_addr_filter_test.sv
module dst_addr_filter_test;
    localparam int N = 6;
    localparam int W = 48;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     ctrl = '0;
    logic [N*W-1:0] table_addr;
    logic [N-1:0]   table_en;
    logic [W-1:0]   dst_addr = '0;
    logic           dst_valid = 1'b0;
    logic           decision_valid, accept;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dst_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .table_addr(table_addr),
        .table_en(table_en), .dst_addr(dst_addr), .dst_valid(dst_valid),
        .decision_valid(decision_valid), .accept(accept)
    );

    localparam logic [W-1:0] U0 = 48'h0200_0000_0010;
    localparam logic [W-1:0] U4 = 48'h0200_0000_0014;
    localparam logic [W-1:0] UM = 48'h0200_0000_0099;
    localparam logic [W-1:0] M5 = 48'h0100_5E00_0001;
    localparam logic [W-1:0] MX = 48'h0100_5E00_00FF;
    localparam logic [W-1:0] BC = 48'hFFFF_FFFF_FFFF;

    // {ctrl, addr, expected accept}
    localparam int NV = 16;
    localparam logic [52:0] VECS [0:NV-1] = '{
        {4'b1000, U0, 1'b1},   // R6 allow hit
        {4'b1000, UM, 1'b0},   // R6 allow miss
        {4'b0000, U0, 1'b0},   // R7 block hit
        {4'b0000, UM, 1'b1},   // R7 block miss
        {4'b1000, U4, 1'b0},   // R8 disabled, allow
        {4'b0000, U4, 1'b1},   // R8 disabled, block
        {4'b0001, BC, 1'b1},   // R1
        {4'b1111, BC, 1'b1},   // R1
        {4'b1000, BC, 1'b0},   // R2
        {4'b0100, BC, 1'b0},   // R2 over pass-all
        {4'b1010, M5, 1'b0},   // R3 drop despite hit
        {4'b0100, M5, 1'b1},   // R4 pass despite block hit
        {4'b1000, M5, 1'b1},   // R5 mode 0 allow hit
        {4'b1000, MX, 1'b0},   // R5 mode 0 allow miss
        {4'b0000, M5, 1'b0},   // R5 mode 0 block hit
        {4'b1110, M5, 1'b1}    // R5 mode 3 allow hit
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic exp, input string req);
        @(negedge clk);
        ctrl = c; dst_addr = a; dst_valid = 1'b1;
        @(negedge clk);
        dst_valid = 1'b0;
        check({req, " valid"}, decision_valid, 1'b1);
        check(req, accept, exp);
    endtask

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) table_addr[i*W +: W] = 48'h0200_0000_0010 + W'(i);
        table_addr[5*W +: W] = M5;
        table_en = 6'b101111;

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 valid", decision_valid, 1'b0);
        check("R10 accept", accept, 1'b0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            apply(VECS[v][52:49], VECS[v][48:1], VECS[v][0], $sformatf("vec%0d", v));

        // R9: no strobe -> no decision, accept held
        apply(4'b1000, U0, 1'b1, "R9 setup");
        @(negedge clk);
        ctrl = 4'b1000; dst_addr = UM;
        @(negedge clk);
        check("R9 no valid", decision_valid, 1'b0);
        check("R9 hold", accept, 1'b1);

        // R8: enabling entry 4 makes it hit
        table_en = 6'b111111;
        apply(4'b1000, U4, 1'b1, "R8 enabled");
        table_en = 6'b101111;

        // R10: reset during a strobe clears outputs
        apply(4'b1000, U0, 1'b1, "R10 setup");
        @(negedge clk);
        rst_n = 1'b0; dst_valid = 1'b1;
        @(negedge clk);
        dst_valid = 1'b0;
        check("R10 mid valid", decision_valid, 1'b0);
        check("R10 mid accept", accept, 1'b0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule